// File: doc/BRIEF.md
# Bus Target Controller

This block is the responding side of a synchronous, multiplexed 32-bit address/data bus. It watches for the start of a transaction and decodes two kinds of access. A memory access is claimed when its command is a memory read or write and the upper address bits fall inside a window set by a writable base register. A configuration access is claimed when a per-slot select input is high and the address and command mark it as a type-0 configuration cycle for function 0. Once it has claimed a cycle, the block drives its device-claim line low, waits a programmable number of clocks, and then signals that it is ready. On a read it supplies data; on a write it accepts data, one byte lane at a time under the active-low lane enables.

Memory bursts step through consecutive 32-bit words of a small local store. A burst that runs past the last word of the window is ended with a disconnect. Configuration accesses are limited to one data phase. When the local side reports busy at the start of a memory access, the block answers with a retry instead. The configuration space holds three registers: a read-only identification word, a timing register that holds the wait count, and the base address register.

Top module: `bus_target`

## Requirements
- R1: A configuration access is claimed only if, in the address phase (the first clock in which `xact_l` is sampled low after being high), `cfg_sel` is 1, `mux_in[1:0]` is 00 and `cmd_be_l` is 1010 (read) or 1011 (write).
- R2: A configuration access whose function field `mux_in[10:8]` is not 000 is not claimed.
- R3: Configuration register index `mux_in[7:2]` selects the register. Index 0 reads as the identification parameter `ID_WORD` and ignores writes. Index 1 holds the wait count in bits [3:0]. Index 4 holds the base address, and its low log2(4*MEM_WORDS) bits always read 0. Every other index reads 0.
- R4: A memory access is claimed when the command is read (0110, 1100 or 1110) or write (0111 or 1111) and `mux_in[31:6]` equals the base register bits [31:6] (the window is 64 bytes with the defaults). All other commands and addresses are not claimed.
- R5: `claim_l` goes low in the first clock after the address phase. `tgt_rdy_l` goes low W clocks after that, where W is the wait count. `claim_l` stays low while `xact_l` is low.
- R6: On a write, byte lane i (bits 8i+7..8i) is updated only if `cmd_be_l[i]` is 0. This holds in both memory and configuration space.
- R7: While `tgt_rdy_l` is low on a read, `mux_out` holds the addressed word. `mux_oe` is high only during a claimed read.
- R8: In a memory burst, successive data phases address successive words. After the first phase, `tgt_rdy_l` stays low with no further wait states.
- R9: If a memory data phase transfers the last word of the window while `xact_l` is still low, the block then drives `halt_l` low and `tgt_rdy_l` high until `xact_l` is sampled high (disconnect).
- R10: A configuration access that keeps `xact_l` low after its first data phase is disconnected after that single phase.
- R11: If `local_busy` is 1 in the address phase of a claimed memory access, the block drives `halt_l` low with `tgt_rdy_l` high and transfers no data (retry). `local_busy` has no effect on configuration accesses.
- R12: After the final transfer, or after `xact_l` is sampled high during a stop, the block spends one clock with `claim_l`, `tgt_rdy_l` and `halt_l` high and `ctl_oe` high. In the next clock `ctl_oe` is low.
- R13: After reset, `claim_l`, `tgt_rdy_l` and `halt_l` are high, `ctl_oe` and `mux_oe` are low, the base register is 0 and the wait count equals `RESET_WAIT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every input is sampled on the rising edge |
| rst_l | input | 1 | Asynchronous active-low reset |
| xact_l | input | 1 | Transaction frame from the initiator, active low |
| ini_rdy_l | input | 1 | Initiator ready, active low |
| mux_in | input | 32 | Multiplexed address/data seen on the bus |
| cmd_be_l | input | 4 | Command in the address phase, active-low byte lane enables in data phases |
| cfg_sel | input | 1 | Per-slot configuration select |
| local_busy | input | 1 | Local side cannot serve a memory access now |
| claim_l | output | 1 | Device claim, active low |
| tgt_rdy_l | output | 1 | Target ready, active low |
| halt_l | output | 1 | Stop request to the initiator, active low |
| ctl_oe | output | 1 | Drive enable for claim_l, tgt_rdy_l and halt_l |
| mux_out | output | 32 | Read data |
| mux_oe | output | 1 | Drive enable for mux_out |

## Verification
A wrong decode or a wrong state in the controller shows up one clock after the address phase. At that point `claim_l` is either missing or present on a cycle that should be ignored, and any of these mismatches are visible at the ports. A wait counter that is off shows as `tgt_rdy_l` falling one or more clocks early or late. A word pointer that is wrong shows as read-back data from the wrong word, or as a disconnect that comes one phase early or late. A fault in the turnaround shows in the clock after the last transfer, as a control line still low or a drive enable that never drops.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_STOP,
    ST_TURN
  } tstate_t;

  localparam logic [3:0] CMD_MRD = 4'b0110;
  localparam logic [3:0] CMD_MWR = 4'b0111;
  localparam logic [3:0] CMD_CRD = 4'b1010;
  localparam logic [3:0] CMD_CWR = 4'b1011;
  localparam logic [3:0] CMD_MRM = 4'b1100;
  localparam logic [3:0] CMD_MRL = 4'b1110;
  localparam logic [3:0] CMD_MWI = 4'b1111;

  localparam logic [5:0] CFG_IDX_ID     = 6'd0;
  localparam logic [5:0] CFG_IDX_TIMING = 6'd1;
  localparam logic [5:0] CFG_IDX_BASE   = 6'd4;

  typedef struct packed {
    logic hit;
    logic is_cfg;
    logic is_write;
  } dec_t;

endpackage

// File: rtl/tgt_decode.sv
module tgt_decode
  import tgt_pkg::*;
#(
  parameter int WIN_BITS = 6,
  localparam int PW = WIN_BITS - 2
) (
  input  logic [31:0]   addr,
  input  logic [3:0]    cmd,
  input  logic          cfg_sel,
  input  logic [31:0]   base,
  output dec_t          dec,
  output logic [PW-1:0] word_idx,
  output logic [5:0]    reg_idx
);

  logic mem_rd, mem_wr, mem_hit, cfg_cmd, cfg_hit;

  always_comb begin
    mem_rd  = (cmd == CMD_MRD) || (cmd == CMD_MRM) || (cmd == CMD_MRL);
    mem_wr  = (cmd == CMD_MWR) || (cmd == CMD_MWI);
    mem_hit = (mem_rd || mem_wr) && (addr[31:WIN_BITS] == base[31:WIN_BITS]);
    cfg_cmd = (cmd == CMD_CRD) || (cmd == CMD_CWR);
    cfg_hit = cfg_sel && (addr[1:0] == 2'b00) && cfg_cmd && (addr[10:8] == 3'd0);

    dec.hit      = mem_hit || cfg_hit;
    dec.is_cfg   = cfg_hit;
    dec.is_write = cfg_hit ? (cmd == CMD_CWR) : mem_wr;
  end

  assign word_idx = addr[WIN_BITS-1:2];
  assign reg_idx  = addr[7:2];

endmodule

// File: rtl/tgt_cfg_regs.sv
module tgt_cfg_regs
  import tgt_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h5A17_0001,
  parameter int          WIN_BITS   = 6,
  parameter int          WAIT_W     = 4,
  parameter int          RESET_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              wr_en,
  input  logic [5:0]        idx,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be_l,
  output logic [31:0]       rd_data,
  output logic [31:0]       base,
  output logic [WAIT_W-1:0] wait_cnt
);

  localparam logic [31:0] BAR_MASK = ~((32'h1 << WIN_BITS) - 32'h1);

  logic [31:0]       bar_q, bar_raw, bar_d;
  logic              bar_en;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              wait_en;

  for (genvar b = 0; b < 4; b++) begin : g_bar_lane
    assign bar_raw[8*b +: 8] = (!be_l[b]) ? wdata[8*b +: 8] : bar_q[8*b +: 8];
  end

  always_comb begin
    bar_d   = bar_raw & BAR_MASK;
    bar_en  = wr_en && (idx == CFG_IDX_BASE);
    wait_d  = wdata[WAIT_W-1:0];
    wait_en = wr_en && (idx == CFG_IDX_TIMING) && !be_l[0];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      bar_q  <= '0;
      wait_q <= WAIT_W'(RESET_WAIT);
    end else begin
      if (bar_en)  bar_q  <= bar_d;
      if (wait_en) wait_q <= wait_d;
    end
  end

  always_comb begin
    case (idx)
      CFG_IDX_ID:     rd_data = ID_WORD;
      CFG_IDX_TIMING: rd_data = 32'(wait_q);
      CFG_IDX_BASE:   rd_data = bar_q;
      default:        rd_data = '0;
    endcase
  end

  assign base     = bar_q;
  assign wait_cnt = wait_q;

endmodule

// File: rtl/tgt_mem.sv
module tgt_mem #(
  parameter int WORDS = 16,
  localparam int PW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [3:0]    be_l,
  output logic [31:0]   rdata
);

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [7:0] lane_q [WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && !be_l[b]) lane_q[addr] <= wdata[8*b +: 8];
    end

    assign rdata[8*b +: 8] = lane_q[addr];
  end

endmodule

// File: rtl/bus_target.sv
module bus_target
  import tgt_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h5A17_0001,
  parameter int          MEM_WORDS  = 16,
  parameter int          WAIT_W     = 4,
  parameter int          RESET_WAIT = 2
) (
  input  logic        clk,
  input  logic        rst_l,
  input  logic        xact_l,
  input  logic        ini_rdy_l,
  input  logic [31:0] mux_in,
  input  logic [3:0]  cmd_be_l,
  input  logic        cfg_sel,
  input  logic        local_busy,
  output logic        claim_l,
  output logic        tgt_rdy_l,
  output logic        halt_l,
  output logic        ctl_oe,
  output logic [31:0] mux_out,
  output logic        mux_oe
);

  localparam int PW       = $clog2(MEM_WORDS);
  localparam int WIN_BITS = PW + 2;
  localparam logic [PW-1:0] LAST_WORD = PW'(MEM_WORDS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_l;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_l = rst_sync_q[1];

  tstate_t           state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]     ptr_q, ptr_d;
  logic [5:0]        creg_q, creg_d;
  logic              is_cfg_q, is_cfg_d;
  logic              is_wr_q, is_wr_d;
  logic              prev_xact_q;

  dec_t              dec;
  logic [PW-1:0]     dec_word;
  logic [5:0]        dec_reg;
  logic [31:0]       base_addr, cfg_rd, mem_rd;
  logic [WAIT_W-1:0] wait_cnt;
  logic              addr_phase, xfer, last_word, mem_we, cfg_we;

  tgt_decode #(.WIN_BITS(WIN_BITS)) u_dec (
    .addr     (mux_in),
    .cmd      (cmd_be_l),
    .cfg_sel  (cfg_sel),
    .base     (base_addr),
    .dec      (dec),
    .word_idx (dec_word),
    .reg_idx  (dec_reg)
  );

  tgt_cfg_regs #(
    .ID_WORD    (ID_WORD),
    .WIN_BITS   (WIN_BITS),
    .WAIT_W     (WAIT_W),
    .RESET_WAIT (RESET_WAIT)
  ) u_cfg (
    .clk      (clk),
    .rst_l    (rst_int_l),
    .wr_en    (cfg_we),
    .idx      (creg_q),
    .wdata    (mux_in),
    .be_l     (cmd_be_l),
    .rd_data  (cfg_rd),
    .base     (base_addr),
    .wait_cnt (wait_cnt)
  );

  tgt_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .wr_en (mem_we),
    .addr  (ptr_q),
    .wdata (mux_in),
    .be_l  (cmd_be_l),
    .rdata (mem_rd)
  );

  always_comb begin
    addr_phase = (state_q == ST_IDLE) && prev_xact_q && !xact_l;
    xfer       = (state_q == ST_XFER) && !ini_rdy_l;
    last_word  = (ptr_q == LAST_WORD);
    mem_we     = xfer && is_wr_q && !is_cfg_q;
    cfg_we     = xfer && is_wr_q && is_cfg_q;
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ptr_d    = ptr_q;
    creg_d   = creg_q;
    is_cfg_d = is_cfg_q;
    is_wr_d  = is_wr_q;
    case (state_q)
      ST_IDLE: begin
        if (addr_phase && dec.hit) begin
          ptr_d    = dec_word;
          creg_d   = dec_reg;
          is_cfg_d = dec.is_cfg;
          is_wr_d  = dec.is_write;
          if (!dec.is_cfg && local_busy) begin
            state_d = ST_STOP;
          end else if (wait_cnt == '0) begin
            state_d = ST_XFER;
          end else begin
            state_d = ST_WAIT;
            cnt_d   = wait_cnt - WAIT_W'(1);
          end
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) state_d = ST_XFER;
        else             cnt_d   = cnt_q - WAIT_W'(1);
      end
      ST_XFER: begin
        if (!ini_rdy_l) begin
          if (xact_l)                     state_d = ST_TURN;
          else if (is_cfg_q || last_word) state_d = ST_STOP;
          else                            ptr_d   = ptr_q + PW'(1);
        end
      end
      ST_STOP: begin
        if (xact_l) state_d = ST_TURN;
      end
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_l) begin
    if (!rst_int_l) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      ptr_q       <= '0;
      creg_q      <= '0;
      is_cfg_q    <= 1'b0;
      is_wr_q     <= 1'b0;
      prev_xact_q <= 1'b1;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      ptr_q       <= ptr_d;
      creg_q      <= creg_d;
      is_cfg_q    <= is_cfg_d;
      is_wr_q     <= is_wr_d;
      prev_xact_q <= xact_l;
    end
  end

  logic claimed;
  always_comb begin
    claimed   = (state_q == ST_WAIT) || (state_q == ST_XFER) || (state_q == ST_STOP);
    claim_l   = !claimed;
    tgt_rdy_l = (state_q != ST_XFER);
    halt_l    = (state_q != ST_STOP);
    ctl_oe    = (state_q != ST_IDLE);
    mux_oe    = claimed && !is_wr_q;
    mux_out   = is_cfg_q ? cfg_rd : mem_rd;
  end

endmodule

// File: rtl/tgt_checker.sv
module tgt_checker (
  input logic clk,
  input logic rst_l,
  input logic xact_l,
  input logic claim_l,
  input logic tgt_rdy_l,
  input logic halt_l,
  input logic ctl_oe,
  input logic mux_oe
);

  // R5: ready never without claim
  p_trdy_after_claim_r5: assert property (@(posedge clk) disable iff (!rst_l)
    !tgt_rdy_l |-> !claim_l);

  // R5: claim is held while the frame is low
  p_claim_hold_r5: assert property (@(posedge clk) disable iff (!rst_l)
    (!claim_l && !xact_l) |=> !claim_l);

  // R9: stop and ready are exclusive
  p_stop_excl_r9: assert property (@(posedge clk) disable iff (!rst_l)
    !halt_l |-> tgt_rdy_l);

  // R12: release of claim comes with all controls high and still driven
  p_turn_high_r12: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(claim_l) |-> (ctl_oe && tgt_rdy_l && halt_l));

  // R12: drive enable drops only after a clock of high controls
  p_release_r12: assert property (@(posedge clk) disable iff (!rst_l)
    $fell(ctl_oe) |-> ($past(claim_l) && $past(ctl_oe)));

  // R7: data is driven only inside a claimed cycle
  p_drive_r7: assert property (@(posedge clk) disable iff (!rst_l)
    mux_oe |-> (ctl_oe && !claim_l));

endmodule

bind bus_target tgt_checker u_chk (
  .clk       (clk),
  .rst_l     (rst_l),
  .xact_l    (xact_l),
  .claim_l   (claim_l),
  .tgt_rdy_l (tgt_rdy_l),
  .halt_l    (halt_l),
  .ctl_oe    (ctl_oe),
  .mux_oe    (mux_oe)
);

// File: tb/tb_bus_target.sv
`timescale 1ns/100ps
module tb_bus_target;

  localparam logic [31:0] ID = 32'h5A17_0001;

  logic        clk = 1'b0;
  logic        rst_l, xact_l, ini_rdy_l, cfg_sel, local_busy;
  logic [31:0] mux_in;
  logic [3:0]  cmd_be_l;
  logic        claim_l, tgt_rdy_l, halt_l, ctl_oe, mux_oe;
  logic [31:0] mux_out;

  always #2.5 clk = ~clk;

  bus_target dut (
    .clk(clk), .rst_l(rst_l), .xact_l(xact_l), .ini_rdy_l(ini_rdy_l),
    .mux_in(mux_in), .cmd_be_l(cmd_be_l), .cfg_sel(cfg_sel),
    .local_busy(local_busy), .claim_l(claim_l), .tgt_rdy_l(tgt_rdy_l),
    .halt_l(halt_l), .ctl_oe(ctl_oe), .mux_out(mux_out), .mux_oe(mux_oe)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  cmd;
    logic        sel;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        claim;
    logic        rd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'b1010, 1'b1, 32'h0000_0000, 4'h0, 32'h0,          1'b1, 1'b1, ID,           4'd3},
    '{4'b1010, 1'b0, 32'h0000_0000, 4'h0, 32'h0,          1'b0, 1'b0, 32'h0,        4'd1},
    '{4'b1010, 1'b1, 32'h0000_0100, 4'h0, 32'h0,          1'b0, 1'b0, 32'h0,        4'd2},
    '{4'b1010, 1'b1, 32'h0000_0001, 4'h0, 32'h0,          1'b0, 1'b0, 32'h0,        4'd1},
    '{4'b1010, 1'b1, 32'h0000_001C, 4'h0, 32'h0,          1'b1, 1'b1, 32'h0,        4'd3},
    '{4'b1011, 1'b1, 32'h0000_0010, 4'h0, 32'h1234_5678,  1'b1, 1'b0, 32'h0,        4'd3},
    '{4'b1010, 1'b1, 32'h0000_0010, 4'h0, 32'h0,          1'b1, 1'b1, 32'h1234_5640, 4'd3},
    '{4'b1011, 1'b1, 32'h0000_0000, 4'h0, 32'hFFFF_FFFF,  1'b1, 1'b0, 32'h0,        4'd3},
    '{4'b1010, 1'b1, 32'h0000_0000, 4'h0, 32'h0,          1'b1, 1'b1, ID,           4'd3},
    '{4'b1011, 1'b1, 32'h0000_0004, 4'hE, 32'hFFFF_FF00,  1'b1, 1'b0, 32'h0,        4'd6},
    '{4'b1010, 1'b1, 32'h0000_0004, 4'h0, 32'h0,          1'b1, 1'b1, 32'h0,        4'd3},
    '{4'b1011, 1'b1, 32'h0000_0004, 4'hF, 32'h0000_0005,  1'b1, 1'b0, 32'h0,        4'd6},
    '{4'b1010, 1'b1, 32'h0000_0004, 4'h0, 32'h0,          1'b1, 1'b1, 32'h0,        4'd6},
    '{4'b0111, 1'b0, 32'h1234_5648, 4'h0, 32'hAABB_CCDD,  1'b1, 1'b0, 32'h0,        4'd4},
    '{4'b0111, 1'b0, 32'h1234_564C, 4'h0, 32'hFFFF_FFFF,  1'b1, 1'b0, 32'h0,        4'd4},
    '{4'b0111, 1'b0, 32'h1234_564C, 4'hA, 32'h1122_3344,  1'b1, 1'b0, 32'h0,        4'd6},
    '{4'b0110, 1'b0, 32'h1234_5648, 4'h0, 32'h0,          1'b1, 1'b1, 32'hAABB_CCDD, 4'd7},
    '{4'b1110, 1'b0, 32'h1234_564C, 4'h0, 32'h0,          1'b1, 1'b1, 32'hFF22_FF44, 4'd6},
    '{4'b0110, 1'b0, 32'h1234_5680, 4'h0, 32'h0,          1'b0, 1'b0, 32'h0,        4'd4},
    '{4'b0111, 1'b0, 32'h0234_5648, 4'h0, 32'h0,          1'b0, 1'b0, 32'h0,        4'd4},
    '{4'b1111, 1'b0, 32'h1234_5650, 4'h0, 32'h0102_0304,  1'b1, 1'b0, 32'h0,        4'd4},
    '{4'b1100, 1'b0, 32'h1234_5650, 4'h0, 32'h0,          1'b1, 1'b1, 32'h0102_0304, 4'd4}
  };

  logic [31:0] wbuf [8];
  logic [31:0] rbuf [8];

  task automatic idle_bus();
    xact_l = 1'b1; ini_rdy_l = 1'b1; cfg_sel = 1'b0;
    mux_in = '0; cmd_be_l = 4'hF;
  endtask

  // one single-phase access; checks the turnaround (R12)
  task automatic single(input logic [3:0] cmd, input logic sel, input logic [31:0] a,
                        input logic [3:0] be, input logic [31:0] wd,
                        output logic claimed, output logic [31:0] rd,
                        output int lat, output logic stopped, output int claim_lat);
    claimed = 1'b0; stopped = 1'b0; rd = '0; lat = 0; claim_lat = 0;
    @(negedge clk);
    xact_l = 1'b0; ini_rdy_l = 1'b1; mux_in = a; cmd_be_l = cmd; cfg_sel = sel;
    @(negedge clk);
    lat = 1;
    xact_l = 1'b1; ini_rdy_l = 1'b0; mux_in = wd; cmd_be_l = be; cfg_sel = 1'b0;
    for (int i = 0; i < 24; i++) begin
      if (!claim_l && claim_lat == 0) claim_lat = lat;
      if (!tgt_rdy_l) begin claimed = 1'b1; rd = mux_out; break; end
      if (!halt_l)    begin claimed = 1'b1; stopped = 1'b1; break; end
      if (claim_l && lat >= 3) break;
      @(negedge clk);
      lat++;
    end
    if (claimed) begin
      @(negedge clk);
      chk(claim_l && tgt_rdy_l && halt_l && ctl_oe, "R12", "turnaround controls",
          {28'h0, claim_l, tgt_rdy_l, halt_l, ctl_oe}, 32'hF);
      idle_bus();
      @(negedge clk);
      chk(!ctl_oe && !mux_oe, "R12", "release after turnaround",
          {30'h0, ctl_oe, mux_oe}, 32'h0);
    end else begin
      idle_bus();
    end
  endtask

  task automatic burst(input logic [3:0] cmd, input logic sel, input logic [31:0] a,
                       input int n, output int done, output logic stopped);
    logic fin;
    done = 0; stopped = 1'b0; fin = 1'b0;
    @(negedge clk);
    xact_l = 1'b0; ini_rdy_l = 1'b1; mux_in = a; cmd_be_l = cmd; cfg_sel = sel;
    @(negedge clk);
    cfg_sel = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (fin || stopped) break;
      if (!tgt_rdy_l) begin
        rbuf[done] = mux_out;
        xact_l = (done == n - 1);
        ini_rdy_l = 1'b0; mux_in = wbuf[done]; cmd_be_l = 4'h0;
        done++;
        if (done == n) fin = 1'b1;
      end else if (!halt_l) begin
        stopped = 1'b1; xact_l = 1'b1; ini_rdy_l = 1'b1;
      end else begin
        xact_l = 1'b0; ini_rdy_l = 1'b0; mux_in = wbuf[done]; cmd_be_l = 4'h0;
      end
      @(negedge clk);
    end
    chk(claim_l && tgt_rdy_l && halt_l && ctl_oe, "R12", "burst turnaround",
        {28'h0, claim_l, tgt_rdy_l, halt_l, ctl_oe}, 32'hF);
    idle_bus();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_l = 1'b0;
    repeat (3) @(negedge clk);
    rst_l = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic claimed, stopped;
    logic [31:0] rd;
    int lat, clat, done;

    rst_l = 1'b0; local_busy = 1'b0;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_l = 1'b1;
    repeat (4) @(negedge clk);

    // R13: reset state at the ports
    chk(claim_l && tgt_rdy_l && halt_l && !ctl_oe && !mux_oe, "R13", "reset outputs",
        {27'h0, claim_l, tgt_rdy_l, halt_l, ctl_oe, mux_oe}, 32'h1C);

    // table of single-phase accesses (R1 R2 R3 R4 R6 R7)
    for (int v = 0; v < NV; v++) begin
      single(VECS[v].cmd, VECS[v].sel, VECS[v].addr, VECS[v].be, VECS[v].wd,
             claimed, rd, lat, stopped, clat);
      chk(claimed == VECS[v].claim, $sformatf("R%0d", VECS[v].req),
          $sformatf("claim vec %0d", v), 32'(claimed), 32'(VECS[v].claim));
      if (VECS[v].rd)
        chk(rd === VECS[v].exp, $sformatf("R%0d", VECS[v].req),
            $sformatf("read vec %0d", v), rd, VECS[v].exp);
    end

    // R13: registers return to reset values
    do_reset();
    single(4'b1010, 1'b1, 32'h04, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(rd == 32'd2, "R13", "timing reg after reset", rd, 32'd2);
    chk(lat == 3 && clat == 1, "R5", "latency with wait 2", 32'(lat), 32'd3);
    single(4'b1010, 1'b1, 32'h10, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(rd == 32'h0, "R13", "base reg after reset", rd, 32'h0);

    // restore base, set wait 3, check latency
    single(4'b1011, 1'b1, 32'h10, 4'h0, 32'h1234_5640, claimed, rd, lat, stopped, clat);
    single(4'b1011, 1'b1, 32'h04, 4'h0, 32'h3, claimed, rd, lat, stopped, clat);
    single(4'b1010, 1'b1, 32'h00, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(lat == 4, "R5", "ready latency with wait 3", 32'(lat), 32'd4);
    chk(clat == 1, "R5", "claim one clock after address", 32'(clat), 32'd1);
    single(4'b1011, 1'b1, 32'h04, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    single(4'b0110, 1'b0, 32'h1234_5640, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(lat == 1 && clat == 1, "R5", "zero wait latency", 32'(lat), 32'd1);

    // R11: retry while busy leaves memory alone
    single(4'b0111, 1'b0, 32'h1234_5648, 4'h0, 32'h0BAD_F00D, claimed, rd, lat, stopped, clat);
    local_busy = 1'b1;
    single(4'b0111, 1'b0, 32'h1234_5648, 4'h0, 32'h1111_1111, claimed, rd, lat, stopped, clat);
    chk(claimed && stopped, "R11", "retry on busy", {30'h0, claimed, stopped}, 32'h3);
    single(4'b1010, 1'b1, 32'h00, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(!stopped && rd == ID, "R11", "config ignores busy", rd, ID);
    local_busy = 1'b0;
    single(4'b0110, 1'b0, 32'h1234_5648, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(rd == 32'h0BAD_F00D, "R11", "memory unchanged by retry", rd, 32'h0BAD_F00D);

    // R8: burst write then burst read of words 4..6
    wbuf[0] = 32'hA0A0_0001; wbuf[1] = 32'hB1B1_0002; wbuf[2] = 32'hC2C2_0003;
    burst(4'b0111, 1'b0, 32'h1234_5650, 3, done, stopped);
    chk(done == 3 && !stopped, "R8", "burst write phases", 32'(done), 32'd3);
    burst(4'b0110, 1'b0, 32'h1234_5650, 3, done, stopped);
    for (int k = 0; k < 3; k++)
      chk(rbuf[k] == wbuf[k], "R8", $sformatf("burst read word %0d", k), rbuf[k], wbuf[k]);
    single(4'b0110, 1'b0, 32'h1234_5654, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(rd == 32'hB1B1_0002, "R8", "second burst word placement", rd, 32'hB1B1_0002);

    // R9: burst running past the window end
    wbuf[0] = 32'h0E0E_0E0E; wbuf[1] = 32'h0F0F_0F0F;
    wbuf[2] = 32'hDEAD_0000; wbuf[3] = 32'hDEAD_0001;
    burst(4'b0111, 1'b0, 32'h1234_5678, 4, done, stopped);
    chk(done == 2 && stopped, "R9", "disconnect at window end", 32'(done), 32'd2);
    single(4'b0110, 1'b0, 32'h1234_567C, 4'h0, 32'h0, claimed, rd, lat, stopped, clat);
    chk(rd == 32'h0F0F_0F0F, "R9", "last window word", rd, 32'h0F0F_0F0F);

    // R10: configuration burst ends after one phase
    burst(4'b1010, 1'b1, 32'h0000_0000, 2, done, stopped);
    chk(done == 1 && stopped, "R10", "config disconnect", 32'(done), 32'd1);
    chk(rbuf[0] == ID, "R10", "config burst data", rbuf[0], ID);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule